// File: doc/BRIEF.md
# Sharer-Directory Coherence Controller

This block sits next to a shared second-level cache. For every tracked line it records which cores hold a copy in their private data caches. It also records whether one of those cores holds the line modified. Each core has its own request channel to the directory, its own snoop channel and its own response strobe. No core is wired to any other core. A read adds the requester to the sharer set. If another core holds the line modified, that core is first asked to write back and keep a shared copy. A write sends invalidations only to the other recorded sharers. Once every acknowledgement has arrived, the writer gets exclusive ownership. Sharers are never sent new data. A core that lost its copy issues a fresh read the next time it needs the line.

The controller handles one transaction at a time. Requests enter on a valid/ready channel per core. A core keeps `req_valid` and its `req_write`/`req_line` fields stable until it sees `req_ready` high at a clock edge. `req_ready` is high for at most one core, and only while no transaction is in progress. So every other request, whatever line it targets, is held back by de-asserting ready until the current transaction has responded. A round-robin pointer picks among simultaneous requesters. After reset the pointer sits at the last core, so core 0 has first priority.

Snoops and responses carry no ready. Snoops are sent as a level per core (`snp_valid`), together with a shared line number and a keep flag. The core answers with a one-cycle `snp_ack`, and `snp_valid` drops in the following cycle. The response is a single-cycle `rsp_valid` strobe to the requester. The line data stands in as one word per line, whose reset value is the line number.

Top module: `coh_directory`

## Requirements
- R1: After reset, `req_ready`, `snp_valid` and `rsp_valid` are all zero with no requests, and the first response for any line returns the line's index as its data word.
- R2: A read to a line with no modified owner, or one whose modified owner is the requester itself, causes no snoop. The response returns the directory's word, and the requester becomes a sharer.
- R3: A write raises `snp_valid` exactly for the recorded sharers other than the writer, with `snp_keep` = 0 (invalidate). Afterwards the writer is the only sharer and the modified owner.
- R4: A write by a core that is the only recorded sharer raises no snoop at all.
- R5: The response is given only after every snooped core has acknowledged. `rsp_valid` is high in the cycle after the edge at which the last acknowledgement is taken, or in the cycle after acceptance when nothing is snooped.
- R6: A read to a line modified by another core snoops only that owner, with `snp_keep` = 1. The response data is the owner's acknowledgement word. Owner and reader then both stay sharers, and the line is no longer modified.
- R7: A write to a line modified by another core takes the owner's acknowledgement word as the new line value and returns it to the writer.
- R8: `req_ready` is at most one-hot, and it is zero from acceptance through the response cycle.
- R9: When several cores request in an idle cycle, the one accepted is the first requester after the previously accepted core, in ascending index order with wrap-around.
- R10: `rsp_valid` is at most one-hot and lasts one cycle. `rsp_excl` is 1 for a write response and 0 for a read response.
- R11: While any `snp_valid` bit is high, `snp_line` equals the line of the accepted request and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Request valid, one bit per core |
| req_ready | output | NCORE | Request accepted, one bit per core |
| req_write | input | NCORE | 1 = write (ownership) request, 0 = read |
| req_line | input | NCORE*LW | Line index per core, core c at bits [c*LW +: LW] |
| snp_valid | output | NCORE | Snoop pending for each core |
| snp_line | output | LW | Line being snooped |
| snp_keep | output | 1 | 1 = write back and keep shared, 0 = invalidate |
| snp_ack | input | NCORE | One-cycle snoop acknowledgement per core |
| ack_data | input | NCORE*DW | Written-back word per core, used from the modified owner |
| rsp_valid | output | NCORE | One-cycle response strobe to the requester |
| rsp_data | output | DW | Line word returned with the response |
| rsp_excl | output | 1 | Response grants exclusive ownership |

## Verification
The bench builds the block with the full six cores but only four lines and 16-bit words. This keeps all six cores colliding on the same few lines. Sharer sets reach every size from empty to six, and both write-back paths (read recall and write invalidate of a modified owner) occur many times. Many idle cycles see several requesters at once, which exercises the round-robin wrap-around past core 5. Acknowledgement latencies vary per core from zero to two cycles, so the last acknowledgement of a multi-core invalidation lands in varying cycles.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_RESP  = 2'd2
  } dir_state_e;
endpackage

// File: rtl/coh_dir_arb.sv
module coh_dir_arb #(
  parameter int N = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] win
);
  localparam int CW = $clog2(N);

  logic [CW-1:0] last_q;

  always_comb begin
    grant = '0;
    win   = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= N) idx = idx - N;
      if (grant == '0 && req[idx]) begin
        grant[idx] = 1'b1;
        win        = CW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          last_q <= CW'(N - 1);
    else if (|grant)     last_q <= win;
  end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table #(
  parameter int NCORE = 6,
  parameter int NLINE = 16,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NLINE)-1:0]   rd_idx,
  output logic [NCORE-1:0]           rd_sharers,
  output logic                       rd_mod,
  output logic [$clog2(NCORE)-1:0]   rd_owner,
  output logic [DW-1:0]              rd_val,
  input  logic [$clog2(NLINE)-1:0]   wr_idx,
  input  logic                       meta_we,
  input  logic [NCORE-1:0]           wr_sharers,
  input  logic                       wr_mod,
  input  logic [$clog2(NCORE)-1:0]   wr_owner,
  input  logic                       val_we,
  input  logic [DW-1:0]              wr_val
);
  localparam int CW = $clog2(NCORE);

  logic [NCORE-1:0] shr_q [NLINE];
  logic             mod_q [NLINE];
  logic [CW-1:0]    own_q [NLINE];
  logic [DW-1:0]    val_q [NLINE];

  assign rd_sharers = shr_q[rd_idx];
  assign rd_mod     = mod_q[rd_idx];
  assign rd_owner   = own_q[rd_idx];
  assign rd_val     = val_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINE; i++) begin
        shr_q[i] <= '0;
        mod_q[i] <= 1'b0;
        own_q[i] <= '0;
        val_q[i] <= DW'(i);
      end
    end else begin
      if (meta_we) begin
        shr_q[wr_idx] <= wr_sharers;
        mod_q[wr_idx] <= wr_mod;
        own_q[wr_idx] <= wr_owner;
      end
      if (val_we) val_q[wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/coh_directory.sv
module coh_directory
  import coh_dir_pkg::*;
#(
  parameter int NCORE = 6,
  parameter int NLINE = 16,
  parameter int DW    = 16,
  localparam int LW   = $clog2(NLINE),
  localparam int CW   = $clog2(NCORE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    req_valid,
  output logic [NCORE-1:0]    req_ready,
  input  logic [NCORE-1:0]    req_write,
  input  logic [NCORE*LW-1:0] req_line,
  output logic [NCORE-1:0]    snp_valid,
  output logic [LW-1:0]       snp_line,
  output logic                snp_keep,
  input  logic [NCORE-1:0]    snp_ack,
  input  logic [NCORE*DW-1:0] ack_data,
  output logic [NCORE-1:0]    rsp_valid,
  output logic [DW-1:0]       rsp_data,
  output logic                rsp_excl
);
  function automatic logic [NCORE-1:0] core_bit(input logic [CW-1:0] i);
    logic [NCORE-1:0] v;
    v    = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  dir_state_e       state_q;
  logic [CW-1:0]    core_q, owner_q;
  logic [LW-1:0]    line_q;
  logic             wr_q, mod_q;
  logic [NCORE-1:0] pend_q, shr_q;

  // arbitration, only offered while idle
  logic [NCORE-1:0] arb_req, grant;
  logic [CW-1:0]    win;
  assign arb_req = (state_q == ST_IDLE) ? req_valid : '0;

  coh_dir_arb #(.N(NCORE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(arb_req), .grant(grant), .win(win)
  );

  logic          accept, win_wr;
  logic [LW-1:0] win_line;
  assign accept    = |grant;
  assign req_ready = grant;
  assign win_wr    = req_write[win];
  assign win_line  = req_line[win*LW +: LW];

  // directory lookup and update
  logic [NCORE-1:0] t_shr, w_shr;
  logic             t_mod, w_mod, meta_we, val_we;
  logic [CW-1:0]    t_own, w_own;
  logic [DW-1:0]    t_val;
  logic [LW-1:0]    rd_idx;
  assign rd_idx = (state_q == ST_IDLE) ? win_line : line_q;

  coh_dir_table #(.NCORE(NCORE), .NLINE(NLINE), .DW(DW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_sharers(t_shr), .rd_mod(t_mod), .rd_owner(t_own), .rd_val(t_val),
    .wr_idx(line_q), .meta_we(meta_we), .wr_sharers(w_shr), .wr_mod(w_mod), .wr_owner(w_own),
    .val_we(val_we), .wr_val(ack_data[owner_q*DW +: DW])
  );

  // snoop targets for the request being accepted
  logic [NCORE-1:0] targets;
  always_comb begin
    if (win_wr)                       targets = t_shr & ~core_bit(win);
    else if (t_mod && t_own != win)   targets = core_bit(t_own);
    else                              targets = '0;
  end

  logic [NCORE-1:0] acked;
  assign acked  = (state_q == ST_SNOOP) ? (pend_q & snp_ack) : '0;
  assign val_we = mod_q && acked[owner_q];

  // new directory entry written in the response cycle
  always_comb begin
    meta_we = (state_q == ST_RESP);
    w_own   = owner_q;
    w_mod   = mod_q;
    w_shr   = shr_q | core_bit(core_q);
    if (wr_q) begin
      w_shr = core_bit(core_q);
      w_mod = 1'b1;
      w_own = core_q;
    end else if (mod_q && owner_q != core_q) begin
      w_shr = core_bit(owner_q) | core_bit(core_q);
      w_mod = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      owner_q <= '0;
      line_q  <= '0;
      wr_q    <= 1'b0;
      mod_q   <= 1'b0;
      pend_q  <= '0;
      shr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          core_q  <= win;
          wr_q    <= win_wr;
          line_q  <= win_line;
          pend_q  <= targets;
          mod_q   <= t_mod;
          owner_q <= t_own;
          shr_q   <= t_shr;
          state_q <= (targets != '0) ? ST_SNOOP : ST_RESP;
        end
        ST_SNOOP: begin
          pend_q <= pend_q & ~acked;
          if ((pend_q & ~acked) == '0) state_q <= ST_RESP;
        end
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign snp_valid = (state_q == ST_SNOOP) ? pend_q : '0;
  assign snp_line  = line_q;
  assign snp_keep  = ~wr_q;
  assign rsp_valid = (state_q == ST_RESP) ? core_bit(core_q) : '0;
  assign rsp_data  = t_val;
  assign rsp_excl  = wr_q;
endmodule

// File: rtl/coh_directory_chk.sv
module coh_directory_chk #(
  parameter int NCORE = 6,
  parameter int LW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCORE-1:0] req_ready,
  input logic [NCORE-1:0] snp_valid,
  input logic [LW-1:0]    snp_line,
  input logic [NCORE-1:0] snp_ack,
  input logic [NCORE-1:0] rsp_valid
);
  p_ready_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_ready_when_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready != '0) |-> (snp_valid == '0 && rsp_valid == '0));

  p_rsp_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0) |=> (rsp_valid == '0));

  p_no_rsp_during_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0) |-> (rsp_valid == '0));

  p_ack_drops_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((snp_valid & snp_ack) != '0) |=> ((snp_valid & $past(snp_valid & snp_ack)) == '0));

  p_snoop_set_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0) |=> ((snp_valid & ~$past(snp_valid)) == '0));

  p_snoop_line_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0) |=> ((snp_valid == '0) || $stable(snp_line)));
endmodule

bind coh_directory coh_directory_chk #(.NCORE(NCORE), .LW(LW)) u_coh_directory_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .snp_valid(snp_valid),
  .snp_line(snp_line), .snp_ack(snp_ack), .rsp_valid(rsp_valid)
);

// File: tb/test_coh_directory.sv
module test_coh_directory;
  localparam int NC = 6;
  localparam int NL = 4;
  localparam int DW = 16;
  localparam int LW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NC-1:0]    req_valid = '0, req_ready, req_write = '0;
  logic [NC*LW-1:0] req_line = '0;
  logic [NC-1:0]    snp_valid, snp_ack = '0, rsp_valid;
  logic [LW-1:0]    snp_line;
  logic             snp_keep, rsp_excl;
  logic [NC*DW-1:0] ack_data = '0;
  logic [DW-1:0]    rsp_data;

  coh_directory #(.NCORE(NC), .NLINE(NL), .DW(DW)) i_coh_directory (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .snp_valid(snp_valid),
    .snp_line(snp_line), .snp_keep(snp_keep), .snp_ack(snp_ack),
    .ack_data(ack_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_excl(rsp_excl)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  logic [NC-1:0] m_shr [NL];
  bit            m_mod [NL];
  int            m_own [NL];
  logic [DW-1:0] m_val [NL];
  logic [DW-1:0] m_l1  [NL];
  bit            m_touched [NL];
  int            last_win = NC - 1;
  int            wcount = 0;

  // transaction in flight
  bit            t_active = 0, t_wr = 0;
  int            t_core = 0, t_line = 0;
  logic [NC-1:0] t_pend = '0;
  string         t_tag = "R2";

  // core agents
  bit want [NC], outst [NC], want_wr [NC];
  int want_line [NC], dly [NC];
  logic [NC-1:0] ack_q = '0;

  function automatic int rr_pick(input logic [NC-1:0] v);
    for (int k = 1; k <= NC; k++) begin
      int c;
      c = (last_win + k) % NC;
      if (v[c]) return c;
    end
    return -1;
  endfunction

  task automatic model_resp();
    bit cap;
    string tag;
    cap = m_mod[t_line] && m_own[t_line] != t_core;
    if (!m_touched[t_line]) tag = "R1";
    else if (cap) tag = t_wr ? "R7" : "R6";
    else tag = t_wr ? "R3" : "R2";
    if (cap) m_val[t_line] = m_l1[t_line];
    chk(rsp_data == m_val[t_line], tag, rsp_data, m_val[t_line]);
    chk(rsp_excl == t_wr, "R10", rsp_excl, t_wr);
    if (t_wr) begin
      m_shr[t_line] = '0;
      m_shr[t_line][t_core] = 1'b1;
      m_mod[t_line] = 1;
      m_own[t_line] = t_core;
      wcount++;
      m_l1[t_line] = DW'(16'h8000 + wcount);
    end else begin
      if (cap) begin
        m_shr[t_line] = '0;
        m_shr[t_line][m_own[t_line]] = 1'b1;
        m_mod[t_line] = 0;
      end
      m_shr[t_line][t_core] = 1'b1;
    end
    m_touched[t_line] = 1;
    outst[t_core] = 0;
    t_active = 0;
  endtask

  task automatic start_txn(input int c);
    t_active = 1;
    t_core = c;
    t_wr = want_wr[c];
    t_line = want_line[c];
    if (t_wr) begin
      t_pend = m_shr[t_line];
      t_pend[c] = 1'b0;
      t_tag = (t_pend == '0) ? "R4" : "R3";
    end else begin
      t_pend = '0;
      if (m_mod[t_line] && m_own[t_line] != c) t_pend[m_own[t_line]] = 1'b1;
      t_tag = (t_pend == '0) ? "R2" : "R6";
    end
    for (int k = 0; k < NC; k++) dly[k] = $urandom % 3;
    want[c] = 0;
    outst[c] = 1;
    last_win = c;
  endtask

  task automatic cycle_step();
    logic [NC-1:0] exp_snp, exp_rsp, exp_rdy, a;
    bit resp_cycle;
    int pick;
    @(negedge clk);
    if (t_active) t_pend = t_pend & ~ack_q;
    exp_snp = (t_active && t_pend != '0) ? t_pend : '0;
    chk(snp_valid == exp_snp, t_active ? t_tag : "R1", snp_valid, exp_snp);
    if (exp_snp != '0) begin
      chk(snp_line == LW'(t_line), "R11", snp_line, t_line);
      chk(snp_keep == !t_wr, t_wr ? "R3" : "R6", snp_keep, !t_wr);
    end
    exp_rsp = '0;
    if (t_active && t_pend == '0) exp_rsp[t_core] = 1'b1;
    chk(rsp_valid == exp_rsp, "R5", rsp_valid, exp_rsp);
    resp_cycle = (exp_rsp != '0);
    if (resp_cycle) model_resp();
    a = '0;
    for (int c = 0; c < NC; c++) begin
      if (snp_valid[c] && !ack_q[c]) begin
        if (dly[c] == 0) a[c] = 1'b1;
        else dly[c]--;
      end
      ack_data[c*DW +: DW] = (m_mod[snp_line] && m_own[snp_line] == c) ? m_l1[snp_line] : DW'(16'hDEAD);
    end
    snp_ack = a;
    ack_q = a;
    for (int c = 0; c < NC; c++) begin
      req_valid[c] = want[c];
      req_write[c] = want_wr[c];
      req_line[c*LW +: LW] = LW'(want_line[c]);
    end
    #1;
    exp_rdy = '0;
    pick = -1;
    if (!t_active && !resp_cycle) begin
      pick = rr_pick(req_valid);
      if (pick >= 0) exp_rdy[pick] = 1'b1;
    end
    chk(req_ready == exp_rdy, (t_active || resp_cycle) ? "R8" : "R9", req_ready, exp_rdy);
    if (pick >= 0) start_txn(pick);
  endtask

  task automatic directed(input int c, input bit wr, input int line);
    want[c] = 1;
    want_wr[c] = wr;
    want_line[c] = line;
    cycle_step();
    while (want[c] || outst[c]) cycle_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_shr[i] = '0; m_mod[i] = 0; m_own[i] = 0;
      m_val[i] = DW'(i); m_l1[i] = '0; m_touched[i] = 0;
    end
    for (int c = 0; c < NC; c++) begin
      want[c] = 0; outst[c] = 0; want_wr[c] = 0; want_line[c] = 0; dly[c] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs after reset
    repeat (3) cycle_step();
    // R1: first reads of each line return the line index
    for (int i = 0; i < NL; i++) directed(i, 0, i);
    // build sharers {0,1,2} on line 0 (R2), then write by 1 invalidates 0 and 2 (R3)
    directed(1, 0, 0);
    directed(2, 0, 0);
    directed(1, 1, 0);
    // sole holder writes again: no snoop (R4)
    directed(1, 1, 0);
    // read of a modified line recalls the owner (R6)
    directed(3, 0, 0);
    // write with two sharers, then a write stealing a modified line (R7)
    directed(4, 1, 0);
    directed(5, 1, 0);
    // owner reading its own modified line (R2)
    directed(5, 0, 0);
    // R9: all cores request at once
    for (int c = 0; c < NC; c++) begin
      want[c] = 1; want_wr[c] = c[0]; want_line[c] = 1;
    end
    // random traffic with concurrent requesters
    for (int n = 0; n < 6000; n++) begin
      for (int c = 0; c < NC; c++) begin
        if (!want[c] && !outst[c] && ($urandom % 4 == 0)) begin
          want[c] = 1;
          want_wr[c] = $urandom % 2;
          want_line[c] = $urandom % NL;
        end
      end
      cycle_step();
    end
    for (int n = 0; n < 200; n++) cycle_step();
    for (int c = 0; c < NC; c++)
      chk(!want[c] && !outst[c], "R5", outst[c], 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule